// File: doc/BRIEF.md
# Doubleword Byte Lane Steering Unit

This unit sits between a core's load/store stage and a data memory whose words are eight bytes wide. Each request carries an access width (one, two, four or eight bytes), a byte address, store data, a sign control for loads and a byte-order select. The unit decides whether the access is naturally aligned within its doubleword. If it is not, the unit raises a fault and issues nothing to memory. If it is, the unit drives a one-cycle memory command with per-lane write strobes and store data placed on the lanes the access covers.

For loads, the memory word comes back on the following cycle. The unit then picks the addressed bytes out of that word, reassembles them in the selected byte order and widens the result to 64 bits, either with zeros or with copies of the item's top bit. The byte order is sampled with each request, so little-endian and big-endian accesses may be freely interleaved. Requests that would straddle a doubleword are never split. They are only reported.

Top module: `lsu_byte_lane`

## Requirements
- R1: A one-byte access (size code 0) is accepted at every offset 0..7 and never raises the fault.
- R2: A two-byte access (size code 1) is accepted at offsets 0, 2, 4 and 6. At odd offsets it raises the fault.
- R3: A four-byte access (size code 2) is accepted only at offsets 0 and 4. At any other offset it raises the fault.
- R4: An eight-byte access (size code 3) is accepted only at offset 0. At any other offset it raises the fault.
- R5: A faulting request is reported on `fault` one cycle after it is presented. It leaves `mem_en` and every strobe low, so memory content is unchanged, and it produces no load response.
- R6: An accepted store drives `mem_be` with exactly the lanes offset..offset+n-1 set, where bit i covers memory byte lane i (data bits 8i+7..8i) and n is the access width in bytes. Loads drive no strobes.
- R7: With `req_big_endian` low, item byte j (j=0 least significant) sits at byte address addr+j, for both stores and loads.
- R8: With `req_big_endian` high, item byte j sits at byte address addr+n-1-j, so the most significant byte is at the item's address.
- R9: A load with `req_signed` high fills bits 63..8n with bit 8n-1 of the loaded item.
- R10: A load with `req_signed` low fills bits 63..8n with zeros.
- R11: Byte order is taken from each request separately, so data stored in one order and loaded in the other comes back byte-reversed.
- R12: The memory command appears one cycle after the request is sampled. `rsp_valid` rises exactly two cycles after the read command, for one cycle.
- R13: While `rst` is high, `mem_en`, `mem_we`, `mem_be`, `fault` and `rsp_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code: 0 byte, 1 two bytes, 2 four bytes, 3 eight bytes |
| req_addr | input | ADDR_W | Byte address; low three bits are the lane offset |
| req_signed | input | 1 | Sign-extend the load result |
| req_big_endian | input | 1 | Byte order for this request: 1 big, 0 little |
| req_wdata | input | DATA_W | Store item, right-aligned |
| mem_en | output | 1 | Memory command strobe |
| mem_we | output | 1 | Memory write command |
| mem_addr | output | ADDR_W-3 | Doubleword index |
| mem_be | output | DATA_W/8 | Per-lane write strobes |
| mem_wdata | output | DATA_W | Lane-placed store data |
| mem_rdata | input | DATA_W | Memory read word, valid the cycle after a read command |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | DATA_W | Extended load result |
| fault | output | 1 | Misalignment reported for the previous request |

## Verification
The bench builds the unit with an 8-bit address, giving 32 doublewords. A 256-entry byte shadow then mirrors the whole memory. Every access width can be driven at all eight lane offsets, and every store, including faulting ones, can be checked against the full memory image. With the 64-bit data width, the eight-byte access and both byte orders are exercised on whole words, so byte reversal between orders is directly visible.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_t;

  // bytes covered by an access of the given width code
  function automatic int item_bytes(input logic [1:0] size);
    return 1 << size;
  endfunction

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_pkg::*;
#(
  parameter int OFF_W = 3
) (
  input  logic [1:0]       size,
  input  logic [OFF_W-1:0] offset,
  output logic             legal
);

  localparam int LANES = 1 << OFF_W;

  logic [OFF_W-1:0] low_mask;
  logic             fits;

  always_comb begin
    low_mask = OFF_W'(item_bytes(size) - 1);
    fits     = item_bytes(size) <= LANES;
    legal    = fits && ((offset & low_mask) == '0);
  end

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int LANES = 8,
  parameter int OFF_W = 3
) (
  input  logic [1:0]         size,
  input  logic [OFF_W-1:0]   offset,
  input  logic               big,
  input  logic [8*LANES-1:0] wdata,
  output logic [LANES-1:0]   be,
  output logic [8*LANES-1:0] lanes
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int         n_b;
    int         rel;
    int         k;
    logic       hit;
    logic [7:0] lane_byte;

    always_comb begin
      n_b = item_bytes(size);
      rel = l - int'(offset);
      hit = (rel >= 0) && (rel < n_b);
      k   = big ? (n_b - 1 - rel) : rel;
      if (!hit) k = 0;
      lane_byte = hit ? wdata[8*k +: 8] : 8'h00;
    end

    assign be[l]          = hit;
    assign lanes[8*l +: 8] = lane_byte;
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int LANES = 8,
  parameter int OFF_W = 3
) (
  input  logic [1:0]         size,
  input  logic [OFF_W-1:0]   offset,
  input  logic               big,
  input  logic               sgn,
  input  logic [8*LANES-1:0] rdata,
  output logic [8*LANES-1:0] value
);

  int   n_top;
  int   top_lane;
  logic fill_bit;

  // lane holding the most significant byte of the item
  always_comb begin
    n_top    = item_bytes(size);
    top_lane = big ? int'(offset) : int'(offset) + n_top - 1;
    top_lane = top_lane & (LANES - 1);
    fill_bit = sgn & rdata[8*top_lane + 7];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_item
    int         n_b;
    int         lane;
    logic [7:0] out_byte;

    always_comb begin
      n_b  = item_bytes(size);
      lane = big ? (int'(offset) + n_b - 1 - j) : (int'(offset) + j);
      lane = lane & (LANES - 1);
      if (j < n_b) out_byte = rdata[8*lane +: 8];
      else         out_byte = {8{fill_bit}};
    end

    assign value[8*j +: 8] = out_byte;
  end

endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_valid,
  input  logic                                 req_write,
  input  logic [1:0]                           req_size,
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic                                 req_signed,
  input  logic                                 req_big_endian,
  input  logic [DATA_W-1:0]                    req_wdata,
  output logic                                 mem_en,
  output logic                                 mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]   mem_addr,
  output logic [DATA_W/8-1:0]                  mem_be,
  output logic [DATA_W-1:0]                    mem_wdata,
  input  logic [DATA_W-1:0]                    mem_rdata,
  output logic                                 rsp_valid,
  output logic [DATA_W-1:0]                    rsp_data,
  output logic                                 fault
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IDX_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0]  req_off;
  logic              legal;
  logic [LANES-1:0]  st_be;
  logic [DATA_W-1:0] st_lanes;
  logic [DATA_W-1:0] ld_value;

  // load context, stage A (command issued) and stage B (data returned)
  logic             a_load, b_load;
  logic [1:0]       a_size, b_size;
  logic [OFF_W-1:0] a_off,  b_off;
  logic             a_sgn,  b_sgn;
  logic             a_big,  b_big;

  assign req_off = req_addr[OFF_W-1:0];

  lsu_align_check #(.OFF_W(OFF_W)) u_align (
    .size   (req_size),
    .offset (req_off),
    .legal  (legal)
  );

  lsu_store_steer #(.LANES(LANES), .OFF_W(OFF_W)) u_steer (
    .size   (req_size),
    .offset (req_off),
    .big    (req_big_endian),
    .wdata  (req_wdata),
    .be     (st_be),
    .lanes  (st_lanes)
  );

  lsu_load_extract #(.LANES(LANES), .OFF_W(OFF_W)) u_extract (
    .size   (b_size),
    .offset (b_off),
    .big    (b_big),
    .sgn    (b_sgn),
    .rdata  (mem_rdata),
    .value  (ld_value)
  );

  logic go, go_st, go_ld;
  assign go    = req_valid && legal;
  assign go_st = go && req_write;
  assign go_ld = go && !req_write;

  // memory command stage
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      fault     <= 1'b0;
    end else begin
      mem_en    <= go;
      mem_we    <= go_st;
      mem_addr  <= req_addr[ADDR_W-1:OFF_W];
      mem_be    <= go_st ? st_be : '0;
      mem_wdata <= go_st ? st_lanes : '0;
      fault     <= req_valid && !legal;
    end
  end

  // load context pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      a_load <= 1'b0;
      a_size <= '0;
      a_off  <= '0;
      a_sgn  <= 1'b0;
      a_big  <= 1'b0;
      b_load <= 1'b0;
      b_size <= '0;
      b_off  <= '0;
      b_sgn  <= 1'b0;
      b_big  <= 1'b0;
    end else begin
      a_load <= go_ld;
      if (go_ld) begin
        a_size <= req_size;
        a_off  <= req_off;
        a_sgn  <= req_signed;
        a_big  <= req_big_endian;
      end
      b_load <= a_load;
      if (a_load) begin
        b_size <= a_size;
        b_off  <= a_off;
        b_sgn  <= a_sgn;
        b_big  <= a_big;
      end
    end
  end

  // response stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= b_load;
      if (b_load) rsp_data <= ld_value;
    end
  end

  logic unused_idx;
  assign unused_idx = ^IDX_W;

endmodule

// File: rtl/lsu_byte_lane_chk.sv
module lsu_byte_lane_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               req_valid,
  input logic [1:0]                         req_size,
  input logic [ADDR_W-1:0]                  req_addr,
  input logic                               mem_en,
  input logic                               mem_we,
  input logic [DATA_W/8-1:0]                mem_be,
  input logic                               rsp_valid,
  input logic                               fault
);

  AST_BYTE_NEVER_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(req_size) == 2'd0) |-> !fault); // R1

  AST_HALF_ODD_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(req_size) == 2'd1 && $past(req_addr[0])) |-> fault); // R2

  AST_WORD_OFFSET_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(req_size) == 2'd2 && $past(req_addr[1:0]) != 2'd0) |-> fault); // R3

  AST_DWORD_OFFSET_FAULTS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(req_size) == 2'd3 && $past(req_addr[2:0]) != 3'd0) |-> fault); // R4

  AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (rst)
    fault |-> (!mem_en && mem_be == '0)); // R5

  AST_STROBE_COUNT: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($countones(mem_be) == (1 << $past(req_size)))); // R6

  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |-> mem_be == '0); // R6

  AST_RSP_TWO_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(mem_en && !mem_we, 2)); // R12

endmodule

bind lsu_byte_lane lsu_byte_lane_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/lsu_byte_lane_test.sv
module lsu_byte_lane_test;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 64;
  localparam int WORDS  = 1 << (ADDR_W - 3);
  localparam int BYTES  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [1:0]        req_size = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_signed = 1'b0;
  logic              req_big_endian = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              mem_en, mem_we;
  logic [ADDR_W-4:0] mem_addr;
  logic [7:0]        mem_be;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              fault;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  lsu_byte_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 29 + 7) ^ 8'h5A;
  endfunction

  // single-cycle synchronous memory
  logic [DATA_W-1:0] mem [0:WORDS-1];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++)
        for (int b = 0; b < 8; b++)
          mem[w][8*b +: 8] <= pat(w * 8 + b);
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  logic [7:0] shadow [0:BYTES-1];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_load(input int size, input int addr, input bit sgn, input bit big);
    int n = 1 << size;
    logic [63:0] v = '0;
    for (int j = 0; j < n; j++)
      v[8*j +: 8] = shadow[(big ? addr + n - 1 - j : addr + j) & (BYTES - 1)];
    if (sgn && v[8*n - 1])
      for (int j = n; j < 8; j++) v[8*j +: 8] = 8'hFF;
    return v;
  endfunction

  task automatic access(input bit wr, input int size, input int addr, input bit sgn,
                        input bit big, input logic [63:0] wd, input string tag);
    int n = 1 << size;
    int off = addr % 8;
    bit ok = (off % n) == 0;
    logic [7:0] ebe = 8'(((1 << n) - 1) << off);
    logic [63:0] eld = exp_load(size, addr, sgn, big);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = 2'(size); req_addr = ADDR_W'(addr);
    req_signed = sgn; req_big_endian = big; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(fault == !ok, {tag, " fault"}, 64'(fault), 64'(!ok));
    if (!ok) begin
      chk(!mem_en && mem_be == 8'h00, "R5 silent on fault", {mem_en, mem_be}, 64'h0);
    end else begin
      chk(mem_en && mem_we == wr, "R12 command one cycle after request", {mem_en, mem_we}, {1'b1, wr});
      if (wr) chk(mem_be == ebe, "R6 strobes", 64'(mem_be), 64'(ebe));
      else    chk(mem_be == 8'h00, "R6 no strobes on load", 64'(mem_be), 64'h0);
    end
    if (wr && ok)
      for (int j = 0; j < n; j++)
        shadow[(big ? addr + n - 1 - j : addr + j) & (BYTES - 1)] = wd[8*j +: 8];
    @(negedge clk);
    if (!wr && ok) chk(!rsp_valid, "R12 no early response", 64'(rsp_valid), 64'h0);
    @(negedge clk);
    if (!wr && ok) begin
      chk(rsp_valid, "R12 response valid", 64'(rsp_valid), 64'h1);
      chk(rsp_data == eld, {tag, " load data"}, rsp_data, eld);
    end else begin
      chk(!rsp_valid, "R5 no response", 64'(rsp_valid), 64'h0);
    end
  endtask

  task automatic t_reset;
    chk(!mem_en && !mem_we && mem_be == 8'h00 && !fault && !rsp_valid, "R13 reset outputs",
        {mem_en, mem_we, mem_be, fault, rsp_valid}, 64'h0);
  endtask

  task automatic t_bytes;
    for (int o = 0; o < 8; o++) begin
      access(1'b0, 0, 8 + o, 1'b0, 1'b0, '0, "R1 R10 byte load");
      access(1'b0, 0, 8 + o, 1'b1, 1'b1, '0, "R1 R9 byte signed load");
      access(1'b1, 0, 16 + o, 1'b0, 1'b0, 64'(8'hC0 + o), "R1 byte store");
    end
    access(1'b0, 3, 16, 1'b0, 1'b0, '0, "R1 R7 byte stores readback");
  endtask

  task automatic t_half;
    for (int o = 0; o < 8; o++)
      access(1'b1, 1, 24 + o, 1'b0, 1'b0, 64'(16'h8100 + o), "R2 R7 half store");
    access(1'b0, 3, 24, 1'b0, 1'b0, '0, "R2 R7 half readback");
    for (int o = 0; o < 8; o += 2) begin
      access(1'b0, 1, 24 + o, 1'b1, 1'b0, '0, "R2 R9 half signed");
      access(1'b0, 1, 24 + o, 1'b0, 1'b1, '0, "R2 R10 R8 half big");
    end
  endtask

  task automatic t_word;
    for (int o = 0; o < 8; o++)
      access(1'b1, 2, 32 + o, 1'b0, 1'b1, 64'h9ABC_0000 + 64'(o), "R3 R8 word store");
    access(1'b0, 2, 32, 1'b1, 1'b1, '0, "R3 R8 R9 word load");
    access(1'b0, 2, 36, 1'b0, 1'b0, '0, "R3 R7 R10 word load");
    access(1'b0, 3, 32, 1'b0, 1'b0, '0, "R3 R8 word readback");
  endtask

  task automatic t_dword;
    for (int o = 0; o < 8; o++)
      access(1'b0, 3, 40 + o, 1'b0, 1'b0, '0, "R4 dword load");
    access(1'b1, 3, 48, 1'b0, 1'b0, 64'h0102_0304_0506_0708, "R11 dword store little");
    access(1'b0, 3, 48, 1'b0, 1'b1, '0, "R11 dword load big");
    access(1'b1, 3, 56, 1'b0, 1'b1, 64'hF1E2_D3C4_B5A6_9788, "R8 dword store big");
    access(1'b0, 2, 56, 1'b1, 1'b0, '0, "R11 R9 word little after big");
  endtask

  task automatic t_misaligned;
    access(1'b1, 2, 65, 1'b0, 1'b0, 64'hDEAD_BEEF, "R5 R3 misaligned store");
    access(1'b1, 3, 67, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R5 R4 misaligned dword");
    access(1'b1, 1, 71, 1'b0, 1'b0, 64'hAAAA, "R5 R2 misaligned half");
    access(1'b0, 3, 64, 1'b0, 1'b0, '0, "R5 memory untouched");
    access(1'b0, 2, 66, 1'b1, 1'b0, '0, "R5 misaligned load");
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < BYTES; i++) shadow[i] = pat(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_bytes();
    t_half();
    t_word();
    t_dword();
    t_misaligned();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule